// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 32,768 bytes (15 address bits, 8 data bits). The host raises a request with an address, a direction and, for a store, a byte. The block then runs the memory's active-low chip-select, output-strobe and write-strobe lines through a fixed sequence that meets the part's minimum timing. The data pins are three-state. The block presents them as a separate input, output and output-enable so that the pad cell can be instantiated outside.

Every timing limit is a parameter in nanoseconds. A package function converts it to clock cycles by dividing by the clock-period parameter, rounding up and never going below one cycle. A load is sampled on the last cycle of its strobe window and returned to the host with a one-cycle acknowledge. After a load, a quiet interval lets the memory's drivers reach high impedance before anything else can happen on the bus. The output strobe stays high for the whole of a store, so the block can drive the write byte from the first cycle of the store. Address, data and strobes come straight from flops.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe and host_ack are 0, and host_ready is 1.
- R2: A load holds mem_ce_n and mem_oe_n low together for exactly RD_CYC consecutive cycles, and mem_we_n stays 1 throughout. RD_CYC is the largest of the rounded-up cycle counts for the read-cycle time, the address access time and the output-strobe access time, which is 4 with the defaults (35 ns, 35 ns, 25 ns at 10 ns).
- R3: When a load ends, host_rdata holds the byte that was on mem_dq_i in the last strobe cycle. host_ack is 1 for exactly one cycle, and that is the first cycle in which the strobes are back at 1. A store also ends with a one-cycle host_ack.
- R4: A store holds mem_ce_n and mem_we_n low together for exactly WR_CYC consecutive cycles, and mem_oe_n stays 1 throughout. WR_CYC is the largest of the rounded-up counts for the write-cycle time, write pulse width, data setup and address-valid-to-end times, which is 4 with the defaults (35, 25, 20, 30 ns).
- R5: During a store, mem_dq_oe is 1 and mem_dq_o equals the accepted byte from the first cycle in which mem_we_n is low up to and including the cycle after mem_we_n returns high. In the following cycle mem_dq_oe is 0.
- R6: After a load, mem_ce_n stays 1 and host_ready stays 0 for GAP_CYC cycles, counted from the acknowledge cycle. GAP_CYC is the rounded-up output-release time, which is 3 with the default of 25 ns.
- R7: A host_req seen while host_ready is 0 is ignored. It starts no strobe, changes no address and produces no extra acknowledge.
- R8: mem_addr equals the address given when the request was accepted. It stays unchanged for every cycle in which mem_ce_n is low, even if host_addr changes.
- R9: mem_oe_n and mem_we_n are never low in the same cycle, and neither is ever low while mem_ce_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request, taken only while host_ready is 1 |
| host_we | input | 1 | 1 = store, 0 = load |
| host_addr | input | 15 | Byte address |
| host_wdata | input | 8 | Byte to store |
| host_ready | output | 1 | Sequencer idle, able to accept a request |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Byte returned by the last load |
| mem_addr | output | 15 | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_o | output | 8 | Byte driven toward the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_i | input | 8 | Byte read from the data pins |

## Verification
The memory model in the bench drives a poison byte until the output strobe has been low for 35 ns. A load that samples too early therefore returns poison instead of the stored byte. Stores and loads are run to address 0 and the top address, with all-zero, all-one and alternating data. The sequence includes a load of a never-written location, an overwrite of an earlier location and a store that follows a load directly; that last case exposes a missing or short quiet interval. One store and one load are interrupted by a stray request while busy, and host_addr is changed after every acceptance, to show that the strobes, mem_addr and the acknowledge count are not affected.

// File: rtl/sramc_pkg.sv
// Package: shared state type and the nanosecond-to-cycle helpers.
// Assumes all timing inputs are non-negative and the clock period is >= 1 ns.
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_GAP,
        ST_WRITE,
        ST_HOLD
    } sram_st_e;

    // Round a delay up to whole clock cycles, never less than one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_tcount.sv
// Down-counter that times one strobe window.
// A load sets the length; done is high in the last cycle of the window.
// Assumes load_val >= 1.
module sramc_tcount #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    // Count the remaining cycles of the current window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign done = (cnt == CNT_W'(1));

endmodule

// File: rtl/sramc_seq.sv
// Strobe sequencer: idle -> read window -> release gap, or
// idle -> write window -> data hold cycle. All strobe outputs are flops.
// Assumes the window lengths fit in CNT_W bits and are >= 1.
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int RD_CYC  = 4,
    parameter int WR_CYC  = 4,
    parameter int GAP_CYC = 3,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic             cnt_done,
    output logic             ready,
    output logic             accept,
    output logic             capture,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe,
    output logic             ack
);

    sram_st_e st;

    // Decode request acceptance and window ends from the state register.
    always_comb begin
        ready    = (st == ST_IDLE);
        accept   = ready && req;
        capture  = (st == ST_READ) && cnt_done;
        cnt_load = accept || capture;
        if (accept)
            cnt_val = we ? CNT_W'(WR_CYC) : CNT_W'(RD_CYC);
        else
            cnt_val = CNT_W'(GAP_CYC);
    end

    // Advance the state and register every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
            ack   <= 1'b0;
        end else begin
            ack <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        ce_n <= 1'b0;
                        if (we) begin
                            we_n  <= 1'b0;
                            dq_oe <= 1'b1;
                            st    <= ST_WRITE;
                        end else begin
                            oe_n <= 1'b0;
                            st   <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (cnt_done) begin
                        ce_n <= 1'b1;
                        oe_n <= 1'b1;
                        ack  <= 1'b1;
                        st   <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (cnt_done) st <= ST_IDLE;
                end
                ST_WRITE: begin
                    if (cnt_done) begin
                        ce_n <= 1'b1;
                        we_n <= 1'b1;
                        ack  <= 1'b1;
                        st   <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    dq_oe <= 1'b0;
                    st    <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sramc_iopath.sv
// Address, write-data and read-data registers.
// The address and write byte are loaded only on acceptance, so they are
// constant for the whole access. The read byte is captured at the end of
// the read window.
module sramc_iopath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [DATA_W-1:0] host_rdata
);

    // Hold the request fields for the duration of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            mem_addr <= host_addr;
            mem_dq_o <= host_wdata;
        end
    end

    // Sample the memory's byte in the last read-window cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= '0;
        else if (capture)
            host_rdata <= mem_dq_i;
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
// Top level: single-byte host port to an asynchronous SRAM.
// Converts the nanosecond timing parameters into cycle counts and
// wires the sequencer, window counter and data registers together.
// Assumes CLK_NS is the true clock period; the pad tristate is outside.
module sram_strobe_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_RC_NS   = 35,
    parameter int T_AA_NS   = 35,
    parameter int T_OE_NS   = 25,
    parameter int T_WC_NS   = 35,
    parameter int T_WP_NS   = 25,
    parameter int T_DW_NS   = 20,
    parameter int T_AW_NS   = 30,
    parameter int T_REL_NS  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int RD_CYC  = max2(max2(ns_to_cyc(T_RC_NS, CLK_NS),
                                       ns_to_cyc(T_AA_NS, CLK_NS)),
                                  ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int WR_CYC  = max2(max2(ns_to_cyc(T_WC_NS, CLK_NS),
                                       ns_to_cyc(T_WP_NS, CLK_NS)),
                                  max2(ns_to_cyc(T_DW_NS, CLK_NS),
                                       ns_to_cyc(T_AW_NS, CLK_NS)));
    localparam int GAP_CYC = ns_to_cyc(T_REL_NS, CLK_NS);
    localparam int MAX_CYC = max2(max2(RD_CYC, WR_CYC), GAP_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             accept;
    logic             capture;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_done;

    sramc_seq #(
        .RD_CYC  (RD_CYC),
        .WR_CYC  (WR_CYC),
        .GAP_CYC (GAP_CYC),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (host_req),
        .we       (host_we),
        .cnt_done (cnt_done),
        .ready    (host_ready),
        .accept   (accept),
        .capture  (capture),
        .cnt_load (cnt_load),
        .cnt_val  (cnt_val),
        .ce_n     (mem_ce_n),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .dq_oe    (mem_dq_oe),
        .ack      (host_ack)
    );

    sramc_tcount #(
        .CNT_W (CNT_W)
    ) u_tcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    sramc_iopath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_iopath (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .mem_dq_i   (mem_dq_i),
        .mem_addr   (mem_addr),
        .mem_dq_o   (mem_dq_o),
        .host_rdata (host_rdata)
    );

endmodule

// File: rtl/sramc_chk.sv
// Checker bound to sram_strobe_ctrl: strobe overlap, minimum pulse
// lengths, data drive under the write strobe, address hold and the
// release gap after a read. Pulse lengths are measured with counters.
module sramc_chk #(
    parameter int ADDR_W  = 15,
    parameter int RD_CYC  = 4,
    parameter int WR_CYC  = 4,
    parameter int GAP_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              dq_oe,
    input logic              ack,
    input logic [ADDR_W-1:0] addr
);

    localparam int SAT = 1000;

    int oe_low_run;
    int we_low_run;
    int since_oe;

    // Measure low pulse lengths and cycles since the output strobe rose.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_low_run <= 0;
            we_low_run <= 0;
            since_oe   <= SAT;
        end else begin
            oe_low_run <= !oe_n ? oe_low_run + 1 : 0;
            we_low_run <= !we_n ? we_low_run + 1 : 0;
            if (!oe_n)
                since_oe <= 0;
            else if (since_oe < SAT)
                since_oe <= since_oe + 1;
        end
    end

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    a_r9_strobe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> !ce_n);

    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(addr));

    a_r2_read_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> (oe_low_run >= RD_CYC));

    a_r4_write_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_low_run >= WR_CYC));

    a_r5_drive_under_we: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> dq_oe);

    a_r5_drive_past_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> dq_oe);

    a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    a_r6_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_n) |-> (since_oe >= GAP_CYC));

endmodule

bind sram_strobe_ctrl sramc_chk #(
    .ADDR_W  (ADDR_W),
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .GAP_CYC (GAP_CYC)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (mem_ce_n),
    .oe_n  (mem_oe_n),
    .we_n  (mem_we_n),
    .dq_oe (mem_dq_oe),
    .ack   (host_ack),
    .addr  (mem_addr)
);

// File: tb/sim_sram_strobe_ctrl.sv
// Bench: behavioural SRAM model (poisoned until the access time has elapsed)
// plus a scoreboard of written bytes; every access is tracked cycle by cycle.
module sim_sram_strobe_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int RD_EXP  = (35 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int WR_EXP  = (35 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int GAP_EXP = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam logic [7:0] POISON = 8'hEE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [14:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready, host_ack;
    logic [7:0]  host_rdata;
    logic [14:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i = POISON;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] array_m [int];
    logic [7:0] score_m [int];
    int oe_low_ns = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_strobe_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ready(host_ready), .host_ack(host_ack),
        .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // Memory model: data valid only 35 ns after select and output strobe.
    always @(negedge clk) begin
        if (!mem_ce_n && !mem_oe_n) oe_low_ns += CLK_PERIOD;
        else oe_low_ns = 0;
        if (oe_low_ns - CLK_PERIOD/2 >= 35)
            mem_dq_i = array_m.exists(int'(mem_addr)) ? array_m[int'(mem_addr)] : 8'h00;
        else
            mem_dq_i = POISON;
        if (!mem_ce_n && !mem_we_n && mem_dq_oe)
            array_m[int'(mem_addr)] = mem_dq_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One access; poke injects a stray request while busy (R7).
    task automatic xfer(input bit w, input logic [14:0] a, input logic [7:0] d, input bit poke);
        int low = 0;
        int n = 0;
        int gap = 0;
        bit other = 0, addr_bad = 0, dq_bad = 0, ce_bad = 0, ack2 = 0;
        logic [7:0] exp_rd;
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = w; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_addr = ~a; host_wdata = ~d; host_req = 1'b0;
        while (!host_ack && n < 40) begin
            n++;
            if (w) begin
                if (!mem_we_n) low++;
                if (!mem_oe_n) other = 1;
                if (!mem_dq_oe || mem_dq_o != d) dq_bad = 1;
            end else begin
                if (!mem_oe_n) low++;
                if (!mem_we_n) other = 1;
            end
            if (mem_addr != a || mem_ce_n) addr_bad = 1;
            host_req = (poke && n == 2);
            host_we  = ~w;
            @(negedge clk);
        end
        host_req = 1'b0;
        chk(host_ack, w ? "R3 store ack" : "R3 load ack", host_ack, 1);
        chk(low == (w ? WR_EXP : RD_EXP), w ? "R4 we_n low cycles" : "R2 oe_n low cycles",
            low, w ? WR_EXP : RD_EXP);
        chk(!other, w ? "R4 oe_n stays high" : "R2 we_n stays high", other, 0);
        chk(!addr_bad, "R8 address held under ce_n", addr_bad, 0);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R3 strobes high at ack",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        if (w) begin
            score_m[int'(a)] = d;
            chk(!dq_bad, "R5 data driven under we_n", dq_bad, 0);
            chk(mem_dq_oe && mem_dq_o == d, "R5 data held after we_n", mem_dq_o, d);
            @(negedge clk);
            chk(!host_ack, "R3 ack single cycle", host_ack, 0);
            chk(!mem_dq_oe, "R5 data released", mem_dq_oe, 0);
        end else begin
            exp_rd = score_m.exists(int'(a)) ? score_m[int'(a)] : 8'h00;
            chk(host_rdata == exp_rd, "R3 read data", host_rdata, exp_rd);
            do begin
                gap++;
                if (gap == 2 && host_ack) ack2 = 1;
                if (!mem_ce_n) ce_bad = 1;
                @(negedge clk);
            end while (!host_ready && gap < 40);
            chk(!ack2, "R3 ack single cycle", ack2, 0);
            chk(gap == GAP_EXP && !ce_bad, "R6 release gap", gap, GAP_EXP);
        end
        if (poke) begin
            @(negedge clk);
            @(negedge clk);
            chk(!host_ack && mem_ce_n, "R7 busy request ignored", {host_ack, mem_ce_n}, 2'b01);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !host_ack,
            "R1 strobes idle in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, host_ack}, 5'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_ready && mem_ce_n && !host_ack, "R1 ready after reset",
            {host_ready, mem_ce_n, host_ack}, 3'b110);

        xfer(1'b1, 15'h0000, 8'h5A, 1'b0);
        xfer(1'b1, 15'h7FFF, 8'hA5, 1'b0);
        xfer(1'b1, 15'h1234, 8'hFF, 1'b0);
        xfer(1'b1, 15'h4321, 8'h00, 1'b0);
        xfer(1'b0, 15'h0000, 8'h00, 1'b0);
        xfer(1'b0, 15'h7FFF, 8'h00, 1'b0);
        xfer(1'b0, 15'h1234, 8'h00, 1'b0);
        xfer(1'b0, 15'h4321, 8'h00, 1'b0);
        xfer(1'b0, 15'h0101, 8'h00, 1'b0);
        xfer(1'b1, 15'h1234, 8'h3C, 1'b1);
        xfer(1'b0, 15'h1234, 8'h00, 1'b1);
        for (int i = 0; i < 8; i++) begin
            xfer(1'b1, 15'(i * 4099), 8'(8'h11 * i + 8'h0F), 1'b0);
            xfer(1'b0, 15'(i * 4099), 8'h00, 1'b0);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule